// File: doc/BRIEF.md
# Latched Binary to Three-Digit Seven-Segment Driver

This block shows an 8-bit unsigned number from 0 to 255 as three decimal digits on seven-segment displays. A hold register keeps the raw binary word. It loads only while two enables, one active-low and one active-high, are both asserted. A combinational shift-and-add-3 stage turns the stored word into hundreds, tens and units. One segment decoder per digit then turns each BCD digit into a segment pattern. The hundreds digit uses a reduced decoder that only covers 0 to 2.

Three controls act on the output without any clock. The first blanks every digit. The second suppresses leading zeros. The third picks active-high or active-low segment drive. Each segment line is given as a value plus a per-digit output-enable, so high impedance is modelled without tri-state logic inside the block. A pad wrapper turns a line with a low enable into a floating pin.

Top module: `bcd7_display`

## Requirements
- R1: After a clock edge with `rst_n` low, the stored value is 0.
- R2: On a rising clock edge where `hold_n` is 0 and `load_en` is 1, the stored value becomes `bin_in`. The display shows it after that edge.
- R3: On any other edge the stored value is kept, whatever `bin_in` does.
- R4: When `blank_all` is 1, all three bits of `dig_oe` are 0.
- R5: With `lz_blank` = 1, the hundreds digit is disabled when it is 0. The tens digit is disabled when both hundreds and tens are 0. The units digit is never disabled for being zero, so an input of 0 shows a single 0.
- R6: With `lz_blank` = 0 and `blank_all` = 0, all three digits are enabled, and leading zeros show as the numeral 0.
- R7: With `invert` = 0 a lit segment reads 1. With `invert` = 1 a lit segment reads 0. This applies to every enabled digit.
- R8: `seg_lvl[6:0]` is units, `[13:7]` is tens and `[20:14]` is hundreds. In each group bit 0 is segment a and bit 6 is segment g. The lit patterns, in hex, for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. So 6 lights a and 9 lights d.
- R9: Every line of a disabled digit reads 0.
- R10: A change on `blank_all`, `lz_blank` or `invert` shows at the outputs at once, with no clock edge, even while the value is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold register |
| rst_n | input | 1 | Synchronous active-low reset |
| bin_in | input | 8 | Unsigned binary value to show |
| hold_n | input | 1 | Active-low load enable |
| load_en | input | 1 | Active-high load enable |
| blank_all | input | 1 | Disables every digit |
| lz_blank | input | 1 | Suppresses leading zeros |
| invert | input | 1 | 1 selects active-low segments |
| seg_lvl | output | 21 | Segment values, three groups of seven |
| dig_oe | output | 3 | Output-enable per digit, bit 0 is units |

## Verification
A wrong stored word shows up as a wrong decimal value. It is visible in the cycle right after the faulty edge: on a load, on a hold, or after reset. A wrong conversion or decoder entry changes the segment pattern of one digit at once, in the same cycle the value is applied. The bench sweeps all 256 values under every setting of the leading-zero and polarity controls, so each entry is exposed. Faults in the control paths appear at the ports without a clock edge, so they are sampled straight after the control changes.

// File: rtl/bcd7_pkg.sv
// Package: shared helpers for the decimal segment driver.
// Assumes segment bit 0 = a ... bit 6 = g, with 1 meaning lit.
package bcd7_pkg;

    localparam int SEG_W = 7;

    // Lit pattern for one decimal digit; codes above 9 give all segments dark.
    function automatic logic [SEG_W-1:0] seg_pattern(input logic [3:0] dig);
        logic [SEG_W-1:0] p;
        case (dig)
            4'd0:    p = 7'h3F;
            4'd1:    p = 7'h06;
            4'd2:    p = 7'h5B;
            4'd3:    p = 7'h4F;
            4'd4:    p = 7'h66;
            4'd5:    p = 7'h6D;
            4'd6:    p = 7'h7D;
            4'd7:    p = 7'h07;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h6F;
            default: p = 7'h00;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bcd7_hold.sv
// Module: input hold register.
// Stores the raw binary word while both enables are asserted (low one low,
// high one high). Otherwise it keeps its contents. Synchronous active-low reset.
module bcd7_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic         hold_n,
    input  logic         load_en,
    output logic [W-1:0] q
);

    logic take;

    // Load qualifier built from the two enables.
    always_comb take = !hold_n && load_en;

    // Register: clear on reset, capture on take, otherwise keep.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (take) q <= d;
    end

    // R2: a qualified edge captures the input word.
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n && load_en) |=> (q == $past(d)));

    // R3: an unqualified edge leaves the stored word untouched.
    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!hold_n && load_en) |=> $stable(q));

endmodule

// File: rtl/bcd7_bin2bcd.sv
// Module: combinational binary to BCD conversion.
// Uses shift-and-add-3 over all input bits. Assumes ND digits are enough
// to hold 2**W-1. Digit k sits at bcd[4k +: 4], with units at k = 0.
module bcd7_bin2bcd #(
    parameter int W  = 8,
    parameter int ND = 3
) (
    input  logic [W-1:0]    bin,
    output logic [4*ND-1:0] bcd
);

    localparam int SH_W = W + 4*ND;

    logic [SH_W-1:0] sh;

    // Shift-and-add-3: correct each nibble, then shift in the next bit.
    always_comb begin
        sh = {{(4*ND){1'b0}}, bin};
        for (int i = 0; i < W; i++) begin
            for (int k = 0; k < ND; k++) begin
                if (sh[W+4*k +: 4] >= 4'd5)
                    sh[W+4*k +: 4] = sh[W+4*k +: 4] + 4'd3;
            end
            sh = sh << 1;
        end
        bcd = sh[W +: 4*ND];
    end

endmodule

// File: rtl/bcd7_seg_dec.sv
// Module: single-digit segment decoder.
// MAX_VAL picks the variant. With 9 it is the full decimal decoder. With a
// smaller value it is a reduced decoder for a digit that never goes past
// MAX_VAL. Codes outside the range give all segments dark.
module bcd7_seg_dec
    import bcd7_pkg::*;
#(
    parameter int MAX_VAL = 9
) (
    input  logic [3:0]       dig,
    output logic [SEG_W-1:0] lit
);

    generate
        if (MAX_VAL >= 9) begin : g_full
            // Full table for 0..9.
            always_comb lit = seg_pattern(dig);
        end else begin : g_reduced
            // Reduced table: only codes up to MAX_VAL are decoded.
            always_comb lit = (int'(dig) <= MAX_VAL) ? seg_pattern(dig) : '0;
        end
    endgenerate

endmodule

// File: rtl/bcd7_display.sv
// Module: top of the latched binary to decimal seven-segment driver.
// It joins the hold register, the BCD converter, one decoder per digit,
// leading-zero suppression, global blanking and polarity. Blanking is given
// as a per-digit output-enable. A disabled digit reads all zeros.
// The controls act combinationally on the stored word.
module bcd7_display
    import bcd7_pkg::*;
#(
    parameter int BIN_W = 8,
    parameter int N_DIG = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [BIN_W-1:0]       bin_in,
    input  logic                   hold_n,
    input  logic                   load_en,
    input  logic                   blank_all,
    input  logic                   lz_blank,
    input  logic                   invert,
    output logic [SEG_W*N_DIG-1:0] seg_lvl,
    output logic [N_DIG-1:0]       dig_oe
);

    localparam int TOP_MAX = ((2**BIN_W) - 1) / (10**(N_DIG-1));
    localparam int TOP_IDX = N_DIG - 1;

    logic [BIN_W-1:0]       held;
    logic [4*N_DIG-1:0]     bcd;
    logic [SEG_W*N_DIG-1:0] lit_all;
    logic [N_DIG-1:0]       lead_zero;

    bcd7_hold #(.W(BIN_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .d       (bin_in),
        .hold_n  (hold_n),
        .load_en (load_en),
        .q       (held)
    );

    bcd7_bin2bcd #(.W(BIN_W), .ND(N_DIG)) u_conv (
        .bin (held),
        .bcd (bcd)
    );

    // One decoder per digit; the top digit gets the reduced variant.
    generate
        for (genvar g = 0; g < N_DIG; g++) begin : g_dig
            localparam int MAXV = (g == TOP_IDX) ? TOP_MAX : 9;
            bcd7_seg_dec #(.MAX_VAL(MAXV)) u_dec (
                .dig (bcd[4*g +: 4]),
                .lit (lit_all[SEG_W*g +: SEG_W])
            );
        end
    endgenerate

    // Leading-zero scan from the top digit down; units never count.
    always_comb begin
        logic run;
        run = 1'b1;
        lead_zero = '0;
        for (int g = N_DIG-1; g >= 1; g--) begin
            run = run && (bcd[4*g +: 4] == 4'd0);
            lead_zero[g] = run;
        end
    end

    // Enables and polarity for every digit group.
    always_comb begin
        for (int g = 0; g < N_DIG; g++) begin
            dig_oe[g] = !blank_all && !(lz_blank && lead_zero[g]);
            seg_lvl[SEG_W*g +: SEG_W] = dig_oe[g]
                ? (lit_all[SEG_W*g +: SEG_W] ^ {SEG_W{invert}})
                : '0;
        end
    end

    // R4: global blanking turns off every digit.
    p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        blank_all |-> (dig_oe == '0));

    // R5: the units digit stays on whenever global blanking is off.
    p_units_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_all |-> dig_oe[0]);

    // R6: with suppression off, all digits are enabled.
    p_all_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_all && !lz_blank) |-> (dig_oe == '1));

    // R7: an enabled units digit always lights some segment, in either polarity.
    p_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dig_oe[0] |-> (seg_lvl[SEG_W-1:0] != {SEG_W{invert}}));

    // R8: the converted top digit stays within the reduced decoder's range.
    p_top_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (int'(bcd[4*TOP_IDX +: 4]) <= TOP_MAX));

endmodule

// File: tb/bcd7_display_tb.sv
`timescale 1ns/1ps
module bcd7_display_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bin_in = 8'd0;
    logic        hold_n = 1'b1;
    logic        load_en = 1'b0;
    logic        blank_all = 1'b0;
    logic        lz_blank = 1'b0;
    logic        invert = 1'b0;
    logic [20:0] seg_lvl;
    logic [2:0]  dig_oe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcd7_display u_dut (
        .clk(clk), .rst_n(rst_n), .bin_in(bin_in), .hold_n(hold_n),
        .load_en(load_en), .blank_all(blank_all), .lz_blank(lz_blank),
        .invert(invert), .seg_lvl(seg_lvl), .dig_oe(dig_oe)
    );

    // Digit pattern table from R8.
    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    // Compare the outputs with the values expected for stored value v.
    task automatic check(input int v, input string req);
        int dd [3];
        logic [2:0]  eoe;
        logic [20:0] elv;
        dd[0] = v % 10; dd[1] = (v / 10) % 10; dd[2] = v / 100;
        eoe[0] = !blank_all;
        eoe[1] = !blank_all && !(lz_blank && dd[2] == 0 && dd[1] == 0);
        eoe[2] = !blank_all && !(lz_blank && dd[2] == 0);
        for (int g = 0; g < 3; g++)
            elv[7*g +: 7] = eoe[g] ? (pat(dd[g]) ^ {7{invert}}) : 7'h00;
        checks++;
        if (seg_lvl !== elv || dig_oe !== eoe) begin
            fails++;
            $display("FAIL %s: value %0d got seg=%h oe=%b expected seg=%h oe=%b",
                     req, v, seg_lvl, dig_oe, elv, eoe);
        end
    endtask

    task automatic load(input int v);
        @(negedge clk);
        bin_in = v[7:0]; hold_n = 1'b0; load_en = 1'b1;
        @(negedge clk);
        hold_n = 1'b1; load_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset value shows 000 with suppression off.
        check(0, "R1");
        rst_n = 1'b1;

        // R8 R5 R6 R7: sweep every value under each lz/polarity setting.
        for (int m = 0; m < 4; m++) begin
            lz_blank = m[0]; invert = m[1];
            for (int v = 0; v < 256; v++) begin
                load(v);
                check(v, "R8");
            end
        end

        // R5: zero with suppression shows a single lit units digit.
        lz_blank = 1'b0; invert = 1'b0;
        load(0);
        lz_blank = 1'b1; #1;
        check(0, "R5");

        // R2 and R3: load 137, then hold against new input under each bad enable pair.
        lz_blank = 1'b0;
        load(137);
        check(137, "R2");
        @(negedge clk); bin_in = 8'd42; hold_n = 1'b1; load_en = 1'b1;
        @(negedge clk); check(137, "R3");
        bin_in = 8'd99; hold_n = 1'b0; load_en = 1'b0;
        @(negedge clk); check(137, "R3");
        bin_in = 8'd7; hold_n = 1'b1; load_en = 1'b0;
        @(negedge clk); check(137, "R3");

        // R10: while held, the controls act with no clock edge.
        load(5);
        hold_n = 1'b1; load_en = 1'b0; bin_in = 8'd200;
        lz_blank = 1'b1; #1; check(5, "R10");
        invert = 1'b1;   #1; check(5, "R10");
        lz_blank = 1'b0; #1; check(5, "R10");

        // R4 and R9: global blank disables all groups and drives zeros.
        blank_all = 1'b1; #1; check(5, "R4");
        invert = 1'b0;    #1; check(5, "R9");
        load(255);
        check(255, "R4");
        blank_all = 1'b0; #1; check(255, "R6");

        // R1: a reset while loading is blocked clears the stored value.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; check(0, "R1");

        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule